// File: doc/BRIEF.md
# Privileged Translation Base Register

This block holds the 64-bit base pointer that a stage-1 table walker uses for the hypervisor translation regime. It also holds a sharing hint bit. Software reaches it through a 64-bit transfer made of two 32-bit words. The low word carries bits 31:0 and the high word carries bits 63:32. Every request comes with the requester's privilege level (0 to 3), a non-secure flag, a "hypervisor level present" flag, a "level 2 enabled" flag and a trap-enable bit from the hypervisor's trap control. One cycle later the block reports exactly one outcome: completed, undefined instruction, or trap to level 2 with a syndrome code.

For the walker, the block continuously presents the effective table base. The alignment boundary `x` is derived from a size field owned by a companion control register. When T is 0 or 1, x = 5 − T. When T is larger, x = 14 − T. Every base bit below `x` is forced to zero. The block also flags an address-size fault whenever any of the stored base bits 47:40 is set.

Top module: `xlat_base_reg`

## Requirements
- R1: After reset, the stored value is zero. No response flag is raised, `walk_base` is 0, `walk_share` is 0 and `size_fault` is 0.
- R2: Each of these requests ends in `rsp_undef`: any request with `hyp_present`=0; any request from level 0; a level 1 request unless both `el2_enabled` and `trap_en` are 1; a level 3 request with `req_ns`=0.
- R3: A level 1 request with `hyp_present`, `el2_enabled` and `trap_en` all 1 ends in `rsp_trap`, with `rsp_syndrome` = 0x04.
- R4: Requests from level 2, and from level 3 with `req_ns`=1, end in `rsp_ok`. A write stores `{wdata_hi, wdata_lo}`. A read returns bits 31:0 on `rsp_rdata_lo` and bits 63:32 on `rsp_rdata_hi`.
- R5: The outcome appears in the cycle after the request, with at most one of ok/undef/trap set. When there is no request, no flag is set. The read data is zero unless the outcome is a read that completed, and the syndrome is zero unless the outcome is a trap.
- R6: A write that ends in undef or trap leaves the stored value unchanged.
- R7: Bits 63:48 always read as zero, and writes to them are ignored.
- R8: Bit 0 is the sharing bit. With `SHARE_EN`=1 (the default) it is stored, read back and driven on `walk_share`.
- R9: `walk_base` carries stored bits 47:x, and its bits x−1:0 are zero. x is 5−T for T in {0,1} and 14−T for T ≥ 2, where T is `size_t`.
- R10: A read returns zero in bits x−1:1, using the `size_t` value present at the time of the read. Bits 47:x and bit 0 are returned as written.
- R11: `size_fault` is 1 exactly when any of the stored bits 47:40 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_el | input | 2 | Privilege level of the requester |
| req_ns | input | 1 | Requester is non-secure |
| hyp_present | input | 1 | Hypervisor level is implemented |
| el2_enabled | input | 1 | Level 2 is enabled for the requester |
| trap_en | input | 1 | Hypervisor trap bit for this register |
| wdata_lo | input | 32 | Write data bits 31:0 |
| wdata_hi | input | 32 | Write data bits 63:32 |
| size_t | input | 3 | Size field from the companion control register |
| rsp_ok | output | 1 | Access completed |
| rsp_undef | output | 1 | Access is an undefined instruction |
| rsp_trap | output | 1 | Access trapped to level 2 |
| rsp_syndrome | output | 8 | Trap syndrome code |
| rsp_rdata_lo | output | 32 | Read data bits 31:0 |
| rsp_rdata_hi | output | 32 | Read data bits 63:32 |
| walk_base | output | 48 | Effective table base for the walker |
| walk_share | output | 1 | Sharing bit for the walker |
| size_fault | output | 1 | Address-size fault |

## Verification
The assertions check on every cycle the properties that can be stated locally:
- the response flags are mutually exclusive;
- the response follows a request by exactly one cycle;
- a completed access came from level 2 or 3 with the hypervisor level present;
- a trap carries syndrome 0x04 and came from level 1;
- undef and trap leave the stored base untouched;
- the reserved high bits read as zero;
- the low four walker bits are always zero.

Only the bench scenarios show the value-level behaviour:
- the exact undef decision for every privilege, security and trap combination;
- the readback and walker masks across all eight size codes;
- the fault threshold at bit 40;
- the round trip of the sharing bit.

// File: rtl/xlat_base_pkg.sv
`timescale 1ns/1ps
package xlat_base_pkg;

  typedef enum logic [1:0] {
    XB_OUT_OK    = 2'd0,
    XB_OUT_UNDEF = 2'd1,
    XB_OUT_TRAP  = 2'd2
  } xb_outcome_e;

  localparam logic [1:0] XB_LVL_USER  = 2'd0;
  localparam logic [1:0] XB_LVL_KERN  = 2'd1;
  localparam logic [1:0] XB_LVL_HYP   = 2'd2;
  localparam logic [1:0] XB_LVL_MON   = 2'd3;

  // Alignment boundary from the size code: small codes select a short
  // boundary, larger codes count down from fourteen. Clamped below at 4.
  function automatic int unsigned xb_align_bit(input int unsigned t);
    int unsigned x;
    if (t < 2)       x = 5 - t;
    else if (t < 10) x = 14 - t;
    else             x = 4;
    return x;
  endfunction

endpackage

// File: rtl/xbr_access_check.sv
`timescale 1ns/1ps
module xbr_access_check
  import xlat_base_pkg::*;
(
  input  logic        hyp_present,
  input  logic [1:0]  req_el,
  input  logic        req_ns,
  input  logic        el2_enabled,
  input  logic        trap_en,
  output xb_outcome_e outcome
);

  // Priority: feature absent, then level-specific rules.
  always_comb begin
    outcome = XB_OUT_UNDEF;
    if (hyp_present) begin
      unique case (req_el)
        XB_LVL_USER: outcome = XB_OUT_UNDEF;
        XB_LVL_KERN: outcome = (el2_enabled && trap_en) ? XB_OUT_TRAP : XB_OUT_UNDEF;
        XB_LVL_HYP:  outcome = XB_OUT_OK;
        XB_LVL_MON:  outcome = req_ns ? XB_OUT_OK : XB_OUT_UNDEF;
        default:     outcome = XB_OUT_UNDEF;
      endcase
    end
  end

endmodule

// File: rtl/xbr_store.sv
`timescale 1ns/1ps
module xbr_store #(
  parameter int ADDR_MSB = 47,
  parameter bit SHARE_EN = 1'b1,
  localparam int LOW_BIT = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_MSB:LOW_BIT] wr_base,
  input  logic                    wr_share,
  output logic [ADDR_MSB:LOW_BIT] base_q,
  output logic                    share_q
);

  logic [ADDR_MSB:LOW_BIT] base_d;

  always_comb begin
    base_d = base_q;
    if (wr_en) base_d = wr_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q <= '0;
    else if (wr_en) base_q <= base_d;
  end

  generate
    if (SHARE_EN) begin : g_share
      logic share_d;
      always_comb begin
        share_d = share_q;
        if (wr_en) share_d = wr_share;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     share_q <= 1'b0;
        else if (wr_en) share_q <= share_d;
      end
    end else begin : g_noshare
      logic unused_share;
      assign unused_share = wr_share;
      assign share_q      = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/xbr_eff_base.sv
`timescale 1ns/1ps
module xbr_eff_base
  import xlat_base_pkg::*;
#(
  parameter int ADDR_MSB  = 47,
  parameter int FAULT_LSB = 40,
  parameter int SZ_W      = 3,
  localparam int LOW_BIT  = 3
) (
  input  logic [ADDR_MSB:LOW_BIT] base_q,
  input  logic                    share_q,
  input  logic [SZ_W-1:0]         size_t,
  output logic [ADDR_MSB:0]       walk_base,
  output logic [63:0]             rd_view,
  output logic                    size_fault
);

  int unsigned             xv;
  logic [ADDR_MSB:LOW_BIT] keep;
  logic [ADDR_MSB:LOW_BIT] masked;

  always_comb xv = xb_align_bit(32'(size_t));

  genvar i;
  generate
    for (i = LOW_BIT; i <= ADDR_MSB; i++) begin : g_keep
      assign keep[i] = (32'(i) >= xv);
    end
  endgenerate

  assign masked     = base_q & keep;
  assign walk_base  = {masked, {LOW_BIT{1'b0}}};
  assign size_fault = |base_q[ADDR_MSB:FAULT_LSB];

  generate
    if (ADDR_MSB < 63) begin : g_resv
      assign rd_view = {{(63-ADDR_MSB){1'b0}}, masked, {(LOW_BIT-1){1'b0}}, share_q};
    end else begin : g_full
      assign rd_view = {masked, {(LOW_BIT-1){1'b0}}, share_q};
    end
  endgenerate

endmodule

// File: rtl/xlat_base_reg.sv
`timescale 1ns/1ps
module xlat_base_reg
  import xlat_base_pkg::*;
#(
  parameter int         ADDR_MSB  = 47,
  parameter int         FAULT_LSB = 40,
  parameter int         SZ_W      = 3,
  parameter int         SYN_W     = 8,
  parameter logic [7:0] SYN_CODE  = 8'h04,
  parameter bit         SHARE_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_el,
  input  logic              req_ns,
  input  logic              hyp_present,
  input  logic              el2_enabled,
  input  logic              trap_en,
  input  logic [31:0]       wdata_lo,
  input  logic [31:0]       wdata_hi,
  input  logic [SZ_W-1:0]   size_t,
  output logic              rsp_ok,
  output logic              rsp_undef,
  output logic              rsp_trap,
  output logic [SYN_W-1:0]  rsp_syndrome,
  output logic [31:0]       rsp_rdata_lo,
  output logic [31:0]       rsp_rdata_hi,
  output logic [ADDR_MSB:0] walk_base,
  output logic              walk_share,
  output logic              size_fault
);

  localparam int LOW_BIT = 3;

  xb_outcome_e             outcome;
  logic [63:0]             wdata;
  logic [63:0]             rd_view;
  logic [ADDR_MSB:LOW_BIT] store_base;
  logic                    store_share;
  logic                    wr_commit;

  logic                    ok_d, undef_d, trap_d;
  logic [SYN_W-1:0]        syn_d;
  logic [63:0]             rdata_d, rdata_q;

  assign wdata = {wdata_hi, wdata_lo};

  logic unused_wdata;
  generate
    if (ADDR_MSB < 63) begin : g_unused_hi
      assign unused_wdata = ^{wdata[63:ADDR_MSB+1], wdata[LOW_BIT-1:1]};
    end else begin : g_unused_lo
      assign unused_wdata = ^wdata[LOW_BIT-1:1];
    end
  endgenerate

  xbr_access_check u_check (
    .hyp_present (hyp_present),
    .req_el      (req_el),
    .req_ns      (req_ns),
    .el2_enabled (el2_enabled),
    .trap_en     (trap_en),
    .outcome     (outcome)
  );

  assign wr_commit = req_valid && req_write && (outcome == XB_OUT_OK);

  xbr_store #(.ADDR_MSB(ADDR_MSB), .SHARE_EN(SHARE_EN)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_commit),
    .wr_base  (wdata[ADDR_MSB:LOW_BIT]),
    .wr_share (wdata[0]),
    .base_q   (store_base),
    .share_q  (store_share)
  );

  xbr_eff_base #(.ADDR_MSB(ADDR_MSB), .FAULT_LSB(FAULT_LSB), .SZ_W(SZ_W)) u_eff (
    .base_q     (store_base),
    .share_q    (store_share),
    .size_t     (size_t),
    .walk_base  (walk_base),
    .rd_view    (rd_view),
    .size_fault (size_fault)
  );

  assign walk_share = store_share;

  // Response next-state
  always_comb begin
    ok_d    = req_valid && (outcome == XB_OUT_OK);
    undef_d = req_valid && (outcome == XB_OUT_UNDEF);
    trap_d  = req_valid && (outcome == XB_OUT_TRAP);
    syn_d   = trap_d ? SYN_W'(SYN_CODE) : '0;
    rdata_d = (ok_d && !req_write) ? rd_view : '0;
  end

  // Response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ok       <= 1'b0;
      rsp_undef    <= 1'b0;
      rsp_trap     <= 1'b0;
      rsp_syndrome <= '0;
      rdata_q      <= '0;
    end else begin
      rsp_ok       <= ok_d;
      rsp_undef    <= undef_d;
      rsp_trap     <= trap_d;
      rsp_syndrome <= syn_d;
      rdata_q      <= rdata_d;
    end
  end

  assign rsp_rdata_lo = rdata_q[31:0];
  assign rsp_rdata_hi = rdata_q[63:32];

endmodule

// File: rtl/xbr_checker.sv
`timescale 1ns/1ps
module xbr_checker #(
  parameter int         ADDR_MSB = 47,
  parameter int         SYN_W    = 8,
  parameter logic [7:0] SYN_CODE = 8'h04
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_el,
  input logic              hyp_present,
  input logic              rsp_ok,
  input logic              rsp_undef,
  input logic              rsp_trap,
  input logic [SYN_W-1:0]  rsp_syndrome,
  input logic [31:0]       rsp_rdata_hi,
  input logic [ADDR_MSB:0] walk_base,
  input logic [ADDR_MSB:3] base_q
);

  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_ok, rsp_undef, rsp_trap}));

  a_r5_answer: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_ok || rsp_undef || rsp_trap));

  a_r5_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(rsp_ok || rsp_undef || rsp_trap));

  a_r2_ok_source: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> ($past(hyp_present) && $past(req_el[1])));

  a_r3_trap_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (rsp_syndrome == SYN_W'(SYN_CODE) && $past(req_el) == 2'd1));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_undef || rsp_trap) |-> $stable(base_q));

  a_r7_resv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> (rsp_rdata_hi[31:ADDR_MSB-31] == '0));

  a_r9_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    walk_base[3:0] == 4'h0);

endmodule

bind xlat_base_reg xbr_checker #(
  .ADDR_MSB (ADDR_MSB),
  .SYN_W    (SYN_W),
  .SYN_CODE (SYN_CODE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_el       (req_el),
  .hyp_present  (hyp_present),
  .rsp_ok       (rsp_ok),
  .rsp_undef    (rsp_undef),
  .rsp_trap     (rsp_trap),
  .rsp_syndrome (rsp_syndrome),
  .rsp_rdata_hi (rsp_rdata_hi),
  .walk_base    (walk_base),
  .base_q       (store_base)
);

// File: tb/xlat_base_reg_test.sv
`timescale 1ns/1ps
module xlat_base_reg_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_el = 2'd0;
  logic        req_ns = 1'b0;
  logic        hyp_present = 1'b1;
  logic        el2_enabled = 1'b0;
  logic        trap_en = 1'b0;
  logic [31:0] wdata_lo = '0;
  logic [31:0] wdata_hi = '0;
  logic [2:0]  size_t = 3'd0;
  logic        rsp_ok, rsp_undef, rsp_trap, walk_share, size_fault;
  logic [7:0]  rsp_syndrome;
  logic [31:0] rsp_rdata_lo, rsp_rdata_hi;
  logic [47:0] walk_base;

  int n_checks = 0;
  int n_fails  = 0;
  logic [63:0] model = '0;

  always #2 clk = ~clk;

  xlat_base_reg uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_el(req_el), .req_ns(req_ns), .hyp_present(hyp_present),
    .el2_enabled(el2_enabled), .trap_en(trap_en), .wdata_lo(wdata_lo),
    .wdata_hi(wdata_hi), .size_t(size_t), .rsp_ok(rsp_ok), .rsp_undef(rsp_undef),
    .rsp_trap(rsp_trap), .rsp_syndrome(rsp_syndrome), .rsp_rdata_lo(rsp_rdata_lo),
    .rsp_rdata_hi(rsp_rdata_hi), .walk_base(walk_base), .walk_share(walk_share),
    .size_fault(size_fault)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int xbound(input int t);
    return (t < 2) ? 5 - t : 14 - t;
  endfunction

  function automatic logic [63:0] exp_read(input logic [63:0] m, input int t);
    logic [63:0] r = m & 64'h0000_FFFF_FFFF_FFF9;
    for (int i = 1; i < xbound(t); i++) r[i] = 1'b0;
    return r;
  endfunction

  function automatic logic [63:0] exp_walk(input logic [63:0] m, input int t);
    logic [63:0] r = m & 64'h0000_FFFF_FFFF_FFF8;
    for (int i = 0; i < xbound(t); i++) r[i] = 1'b0;
    return r;
  endfunction

  function automatic logic [2:0] flags();
    return {rsp_ok, rsp_undef, rsp_trap};
  endfunction

  // Issue one request; on return the registered outcome is on the outputs.
  task automatic access(input logic wr, input logic [1:0] el, input logic ns,
                        input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_el = el; req_ns = ns;
    {wdata_hi, wdata_lo} = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic read_back(input string tag);
    access(1'b0, 2'd2, 1'b0, 64'h0);
    check({tag, " read ok"}, 64'(flags()), 64'b100);
    check({tag, " read data"}, {rsp_rdata_hi, rsp_rdata_lo}, exp_read(model, int'(size_t)));
  endtask

  task automatic t_reset();
    check("R1 flags idle", 64'(flags()), 64'h0);
    check("R1 walk_base", 64'(walk_base), 64'h0);
    check("R1 walk_share", 64'(walk_share), 64'h0);
    check("R1 size_fault", 64'(size_fault), 64'h0);
    read_back("R1");
  endtask

  task automatic t_el2_rw();
    logic [63:0] d = 64'hFFFF_0012_3456_7FF9;
    size_t = 3'd0;
    access(1'b1, 2'd2, 1'b0, d);
    check("R4 el2 write ok", 64'(flags()), 64'b100);
    check("R5 write rdata zero", {rsp_rdata_hi, rsp_rdata_lo}, 64'h0);
    model = d & 64'h0000_FFFF_FFFF_FFF9;
    read_back("R4 el2");
    check("R7 reserved read zero", 64'(rsp_rdata_hi[31:16]), 64'h0);
    check("R8 share on", 64'(walk_share), 64'h1);
    check("R8 share readback", 64'(rsp_rdata_lo[0]), 64'h1);
    check("R10 x=5 readback", {rsp_rdata_hi, rsp_rdata_lo}, 64'h0000_0012_3456_7FE1);
  endtask

  task automatic t_size_sweep();
    logic [63:0] d = 64'h0000_00A5_5A5A_5FFF;
    access(1'b1, 2'd2, 1'b0, d);
    model = d & 64'h0000_FFFF_FFFF_FFF9;
    for (int t = 0; t < 8; t++) begin
      size_t = 3'(t);
      #1;
      check($sformatf("R9 walk_base T=%0d", t), 64'(walk_base), exp_walk(model, t));
      read_back($sformatf("R10 T=%0d", t));
    end
    size_t = 3'd7;
    #1;
    check("R9 T=7 walk_base", 64'(walk_base), 64'h0000_00A5_5A5A_5F80);
  endtask

  task automatic t_fault();
    access(1'b1, 2'd2, 1'b0, 64'h0000_0100_0000_0000);
    model = 64'h0000_0100_0000_0000;
    #1;
    check("R11 bit40 fault", 64'(size_fault), 64'h1);
    access(1'b1, 2'd2, 1'b0, 64'h0000_00FF_FFFF_FFF8);
    model = 64'h0000_00FF_FFFF_FFF8;
    #1;
    check("R11 below bit40 no fault", 64'(size_fault), 64'h0);
    access(1'b1, 2'd2, 1'b0, 64'h0000_8000_0000_0000);
    model = 64'h0000_8000_0000_0000;
    #1;
    check("R11 bit47 fault", 64'(size_fault), 64'h1);
  endtask

  task automatic t_undef();
    logic [63:0] junk = 64'h0000_1111_2222_3338;
    hyp_present = 1'b0;
    access(1'b1, 2'd2, 1'b0, junk);
    check("R2 no hyp undef", 64'(flags()), 64'b010);
    hyp_present = 1'b1;
    read_back("R6 after no-hyp write");
    access(1'b1, 2'd0, 1'b1, junk);
    check("R2 level0 undef", 64'(flags()), 64'b010);
    el2_enabled = 1'b0; trap_en = 1'b1;
    access(1'b1, 2'd1, 1'b1, junk);
    check("R2 level1 el2 off undef", 64'(flags()), 64'b010);
    el2_enabled = 1'b1; trap_en = 1'b0;
    access(1'b1, 2'd1, 1'b1, junk);
    check("R2 level1 no trap undef", 64'(flags()), 64'b010);
    check("R5 undef syndrome zero", 64'(rsp_syndrome), 64'h0);
    access(1'b1, 2'd3, 1'b0, junk);
    check("R2 level3 secure undef", 64'(flags()), 64'b010);
    access(1'b0, 2'd3, 1'b0, junk);
    check("R5 undef read rdata zero", {rsp_rdata_hi, rsp_rdata_lo}, 64'h0);
    read_back("R6 after undef writes");
  endtask

  task automatic t_trap();
    el2_enabled = 1'b1; trap_en = 1'b1;
    access(1'b1, 2'd1, 1'b0, 64'h0000_0022_4444_6668);
    check("R3 trap flag", 64'(flags()), 64'b001);
    check("R3 syndrome", 64'(rsp_syndrome), 64'h04);
    el2_enabled = 1'b0; trap_en = 1'b0;
    read_back("R6 after trap write");
  endtask

  task automatic t_el3();
    logic [63:0] d = 64'h0000_0033_7777_0000;
    access(1'b1, 2'd3, 1'b1, d);
    check("R4 el3 ns write ok", 64'(flags()), 64'b100);
    model = d;
    access(1'b0, 2'd3, 1'b1, 64'h0);
    check("R4 el3 ns read", {rsp_rdata_hi, rsp_rdata_lo}, exp_read(model, int'(size_t)));
  endtask

  task automatic t_idle_share();
    @(negedge clk);
    check("R5 idle no flags", 64'(flags()), 64'h0);
    access(1'b1, 2'd2, 1'b0, 64'h0000_0000_0000_1000);
    model = 64'h0000_0000_0000_1000;
    check("R8 share cleared", 64'(walk_share), 64'h0);
    read_back("R8 share off");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_el2_rw();
    t_size_sweep();
    t_fault();
    t_undef();
    t_trap();
    t_el3();
    t_idle_share();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule